// File: doc/BRIEF.md
# Streaming Bit-Matrix Transpose Unit

The block takes a stream of n-bit words, packed into 128-bit input beats, and groups every n consecutive words into a square bit matrix. Word i of a group is row i. When a group is complete, the block emits its transpose as n words, one per cycle. Output word j holds bit j of every input row, with row i's bit landing at position i. A mode input chooses n = 32 (four words per beat) or n = 64 (two words per beat).

Each of the n column registers shifts several bits per accepted beat: four in 32-bit mode and two in 64-bit mode. Each shifted bit comes from one packed word. There are two complete column banks working as a ping-pong pair. One bank fills while the other drains, so input transfer overlaps the output of the previous matrix. Both sides use valid/ready handshakes.

Top module: `bit_transpose_stream`

## Requirements
- R1: Output word j of a matrix has bit i equal to bit j of input row i, for all i, j below n. In 32-bit mode, output bits 63:32 are zero.
- R2: Within a beat, packed words are ordered from the least-significant end. Bits [n-1:0] carry the lower-indexed row. A 32-bit matrix closes after 8 accepted beats and a 64-bit matrix after 32.
- R3: mode_i = 0 selects n = 32 and mode_i = 1 selects n = 64. The mode is taken only while no matrix is held or partly loaded. A change made at any other time has no effect until both banks are empty again.
- R4: Output words leave in ascending column order, starting at column 0. out_last_o is high on the n-th word of each matrix and on no other word.
- R5: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o and out_last_o keep their values.
- R6: in_ready_o is low only when both banks hold complete matrices that have not been fully read.
- R7: out_valid_o rises in the cycle after the last beat of a matrix is accepted, provided no other matrix is pending. With out_ready_i held high, one word leaves per cycle.
- R8: While rst_ni is low, both banks are empty, all counters are cleared, out_valid_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Matrix size request: 0 for 32, 1 for 64 |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat may be accepted |
| in_data_i | input | BEAT_W (128) | Packed input words, lowest row in low bits |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Consumer takes the output word |
| out_data_o | output | MAX_N (64) | Transposed column word |
| out_last_o | output | 1 | Last word of the current matrix |

## Verification
The embedded assertions check the following on every cycle:
- output hold under back-pressure;
- mode capture only while idle;
- a stall only when both banks are full;
- the column counter wrapping after the last word;
- a zero upper half in 32-bit mode.

Other behaviour shows up only in the bench scenarios, where a behavioural queue model is compared with the ports on every clock:
- the actual bit relation of the transpose;
- the packing order of words in a beat;
- the beat count per matrix;
- the effect of a mode request toggled in the middle of a matrix;
- overlap of loading and draining under random back-pressure.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } tp_mode_e;
endpackage

// File: rtl/tp_col_bank.sv
module tp_col_bank
  import tp_pkg::*;
#(
  parameter int MAX_N  = 64,
  parameter int BEAT_W = 128
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     shift_i,
  input  tp_mode_e                 mode_i,
  input  logic [BEAT_W-1:0]        beat_i,
  input  logic [$clog2(MAX_N)-1:0] rd_idx_i,
  output logic [MAX_N-1:0]         rd_word_o
);
  localparam int NW = MAX_N / 2;
  localparam int KW = BEAT_W / MAX_N;
  localparam int KN = BEAT_W / NW;

  logic [MAX_N*MAX_N-1:0] cols_flat;

  for (genvar j = 0; j < MAX_N; j++) begin : g_col
    logic [MAX_N-1:0] col_q;
    logic [KW-1:0]    ins_w;
    logic [KN-1:0]    ins_n;

    always_comb begin
      for (int w = 0; w < KW; w++) ins_w[w] = beat_i[w*MAX_N + j];
    end

    if (j < NW) begin : g_narrow
      always_comb begin
        for (int w = 0; w < KN; w++) ins_n[w] = beat_i[w*NW + j];
      end
    end else begin : g_unused
      assign ins_n = '0;
    end

    // shift right, new rows enter at the top; oldest row ends lowest
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                col_q <= '0;
      else if (shift_i) begin
        if (mode_i == MODE_WIDE)  col_q <= {ins_w, col_q[MAX_N-1:KW]};
        else                      col_q <= {ins_n, col_q[MAX_N-1:KN]};
      end
    end

    assign cols_flat[j*MAX_N +: MAX_N] = col_q;
  end

  logic [MAX_N-1:0] sel_col;
  assign sel_col   = cols_flat[rd_idx_i*MAX_N +: MAX_N];
  assign rd_word_o = (mode_i == MODE_WIDE) ? sel_col
                                           : {{NW{1'b0}}, sel_col[MAX_N-1:NW]};
endmodule

// File: rtl/tp_ctrl.sv
module tp_ctrl
  import tp_pkg::*;
#(
  parameter int MAX_N  = 64,
  parameter int BEAT_W = 128
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  tp_mode_e                 mode_req_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic                     out_ready_i,
  output logic                     out_valid_o,
  output logic                     out_last_o,
  output logic                     accept_o,
  output logic                     wr_sel_o,
  output logic                     rd_sel_o,
  output tp_mode_e                 mode_o,
  output logic [$clog2(MAX_N)-1:0] rd_idx_o
);
  localparam int IDX_W   = $clog2(MAX_N);
  localparam int NW      = MAX_N / 2;
  localparam int BEATS_W = MAX_N * MAX_N / BEAT_W;
  localparam int BEATS_N = NW * NW / BEAT_W;
  localparam int BC_W    = $clog2(BEATS_W + 1);

  logic [1:0]       full_q, full_d;
  logic             wr_sel_q, rd_sel_q;
  logic [BC_W-1:0]  beat_cnt_q;
  logic [IDX_W-1:0] out_cnt_q;
  tp_mode_e         mode_q;
  logic             idle, beat_last, take;

  assign idle       = (full_q == 2'b00) && (beat_cnt_q == '0);
  assign mode_o     = idle ? mode_req_i : mode_q;
  assign in_ready_o = !full_q[wr_sel_q];
  assign accept_o   = in_valid_i && in_ready_o;
  assign beat_last  = beat_cnt_q == ((mode_o == MODE_WIDE) ? BC_W'(BEATS_W - 1)
                                                           : BC_W'(BEATS_N - 1));
  assign out_valid_o = full_q[rd_sel_q];
  assign out_last_o  = out_valid_o &&
                       out_cnt_q == ((mode_q == MODE_WIDE) ? IDX_W'(MAX_N - 1)
                                                           : IDX_W'(NW - 1));
  assign take     = out_valid_o && out_ready_i;
  assign wr_sel_o = wr_sel_q;
  assign rd_sel_o = rd_sel_q;
  assign rd_idx_o = out_cnt_q;

  always_comb begin
    full_d = full_q;
    if (accept_o && beat_last) full_d[wr_sel_q] = 1'b1;
    if (take && out_last_o)    full_d[rd_sel_q] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q     <= '0;
      wr_sel_q   <= 1'b0;
      rd_sel_q   <= 1'b0;
      beat_cnt_q <= '0;
      out_cnt_q  <= '0;
      mode_q     <= MODE_NARROW;
    end else begin
      full_q <= full_d;
      mode_q <= mode_o;
      if (accept_o) begin
        if (beat_last) begin
          beat_cnt_q <= '0;
          wr_sel_q   <= !wr_sel_q;
        end else begin
          beat_cnt_q <= beat_cnt_q + 1'b1;
        end
      end
      if (take) begin
        if (out_last_o) begin
          out_cnt_q <= '0;
          rd_sel_q  <= !rd_sel_q;
        end else begin
          out_cnt_q <= out_cnt_q + 1'b1;
        end
      end
    end
  end

  AST_MODE_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> $past(idle)) else $error("mode moved"); // R3
  AST_STALL_BOTH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> (full_q == 2'b11)) else $error("early stall"); // R6
  AST_LAST_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && out_last_o) |=> (out_cnt_q == '0)) else $error("no wrap"); // R4
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |-> $past(out_ready_i)) else $error("valid dropped"); // R5
endmodule

// File: rtl/bit_transpose_stream.sv
module bit_transpose_stream
  import tp_pkg::*;
#(
  parameter int MAX_N  = 64,
  parameter int BEAT_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [BEAT_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [MAX_N-1:0]  out_data_o,
  output logic              out_last_o
);
  localparam int IDX_W = $clog2(MAX_N);
  localparam int NW    = MAX_N / 2;

  logic             accept, wr_sel, rd_sel;
  tp_mode_e         mode_eff;
  logic [IDX_W-1:0] rd_idx;
  logic [MAX_N-1:0] rd_word [2];

  tp_ctrl #(.MAX_N(MAX_N), .BEAT_W(BEAT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_req_i  (tp_mode_e'(mode_i)),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .accept_o    (accept),
    .wr_sel_o    (wr_sel),
    .rd_sel_o    (rd_sel),
    .mode_o      (mode_eff),
    .rd_idx_o    (rd_idx)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    tp_col_bank #(.MAX_N(MAX_N), .BEAT_W(BEAT_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .shift_i   (accept && (wr_sel == b[0])),
      .mode_i    (mode_eff),
      .beat_i    (in_data_i),
      .rd_idx_i  (rd_idx),
      .rd_word_o (rd_word[b])
    );
  end

  assign out_data_o = rd_word[rd_sel];

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_last_o))) else $error("hold"); // R5
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && mode_eff == MODE_NARROW) |-> (out_data_o[MAX_N-1:NW] == '0)) else $error("upper"); // R1
endmodule

// File: tb/bit_transpose_stream_tb.sv
module bit_transpose_stream_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_sel = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [63:0]  out_data;
  logic         out_last;

  int  errors = 0, checks = 0, cycles = 0;
  bit  rand_ready = 1'b0;
  bit  run_chk = 1'b0;

  logic [63:0] rows_q [$];
  logic [64:0] exp_q  [$];
  int  pending = 0;
  bit  mode_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_transpose_stream u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_sel),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_last_o(out_last)
  );

  task automatic chk(bit ok, string tag, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, evaluated between edges
  always @(negedge clk) begin
    logic [64:0] e;
    logic [63:0] row, word;
    bit idle, hs_in, hs_out;
    int n, k;
    if (rst_n && run_chk) begin
      chk(in_ready == (pending < 2), "R6", {64'b0, in_ready}, {64'b0, pending < 2});
      chk(out_valid == (pending > 0), "R7", {64'b0, out_valid}, {64'b0, pending > 0});
      if (out_valid) begin
        e = (exp_q.size() > 0) ? exp_q[0] : '1;
        chk(out_data == e[63:0], "R1 R2 R3 R5", {1'b0, out_data}, {1'b0, e[63:0]});
        chk(out_last == e[64], "R4", {64'b0, out_last}, {64'b0, e[64]});
      end
      idle   = (pending == 0) && (rows_q.size() == 0);
      hs_in  = in_valid && in_ready;
      hs_out = out_valid && out_ready;
      if (hs_out && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        if (e[64]) pending--;
      end
      if (idle) mode_m = mode_sel;
      if (hs_in) begin
        n = mode_m ? 64 : 32;
        k = 128 / n;
        for (int w = 0; w < k; w++) begin
          row = mode_m ? in_data[w*64 +: 64] : {32'b0, in_data[w*32 +: 32]};
          rows_q.push_back(row);
        end
        if (rows_q.size() == n) begin
          for (int j = 0; j < n; j++) begin
            word = '0;
            for (int i = 0; i < n; i++) word[i] = rows_q[i][j];
            exp_q.push_back({j == n - 1, word});
          end
          rows_q.delete();
          pending++;
        end
      end
    end
  end

  always @(posedge clk) begin
    #1 out_ready = rand_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  task automatic final_report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      final_report();
    end
  end

  task automatic send(logic [127:0] d);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // kind 0 random, 1 corner bits, 2 flip mode request mid-matrix
  task automatic send_matrix(bit wide, int kind);
    int beats = wide ? 32 : 8;
    logic [127:0] d;
    mode_sel = wide;
    for (int b = 0; b < beats; b++) begin
      if (kind == 1) begin
        d = '0;
        if (b == 0) d[wide ? 63 : 31] = 1'b1;
        if (b == beats - 1) d[wide ? 64 : 96] = 1'b1;
      end else begin
        d = {$urandom, $urandom, $urandom, $urandom};
      end
      if (kind == 2 && b == 2) mode_sel = !wide;
      send(d);
      if ($urandom_range(0, 3) == 0) begin
        @(posedge clk); #1;
      end
    end
    mode_sel = wide;
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    run_chk  = 1'b0;
    rst_n    = 1'b0;
    #2;
    chk(!out_valid, "R8", {64'b0, out_valid}, 65'd0);
    chk(in_ready, "R8", {64'b0, in_ready}, 65'd1);
    rows_q.delete();
    exp_q.delete();
    pending = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    run_chk = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    do_reset();
    send_matrix(1'b0, 0);
    send_matrix(1'b1, 0);
    send_matrix(1'b0, 1);
    send_matrix(1'b1, 1);
    rand_ready = 1'b1;
    for (int m = 0; m < 6; m++) send_matrix(1'b0, 0);
    for (int m = 0; m < 4; m++) send_matrix(1'b1, 0);
    rand_ready = 1'b0;
    while (exp_q.size() > 0) @(posedge clk);
    #1;
    send_matrix(1'b0, 2);
    while (exp_q.size() > 0) @(posedge clk);
    #1;
    send_matrix(1'b1, 2);
    send_matrix(1'b0, 0);
    send_matrix(1'b1, 0);
    repeat (5) @(posedge clk);
    #1;
    do_reset();
    send_matrix(1'b1, 0);
    while (exp_q.size() > 0 || pending > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    final_report();
  end
endmodule